// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit carries out one memory-style instruction at a time for a simple 32-bit word machine. A `start` pulse presents an instruction word together with the already-advanced program counter. The unit decodes the instruction and forms an effective address, which is either a base register plus a 17-bit signed offset or the program counter plus a 22-bit signed offset. It then either reads memory, writes memory, or returns the address itself to the register file.

Memory accesses use a request/completion handshake of variable length. The unit raises a read or write strobe and holds the address and data steady until memory answers with `mem_ack`. After that it writes the loaded word back, if there is one, and raises `done` for one cycle. The register file is outside the block. The unit drives the two register selects from the instruction fields and takes the read data back combinationally.

Top module: `ls_addr_unit`

## Requirements
- R1: Field positions: opcode is instr[31:27], target/source register t is instr[26:22], base register b is instr[21:17], long offset is instr[21:0], short offset is instr[16:0]. When b is 0, the displacement address is the sign-extended short offset alone, whatever register 0 holds.
- R2: When b is nonzero, the displacement address is base_data (the contents of register b) plus the sign-extended short offset, modulo 2^32. Opcodes 1, 3 and 5 use this address.
- R3: The relative address is pc_next plus the sign-extended long offset, modulo 2^32. Opcodes 2, 4 and 6 use this address.
- R4: Opcodes 1 and 2 (loads) raise mem_rd with mem_addr set to the effective address. One cycle after the cycle in which mem_ack is seen, the unit writes mem_rdata into register t (rf_we, rf_wsel, rf_wdata) and raises done in that same cycle.
- R5: Opcodes 3 and 4 (stores) raise mem_wr with mem_addr and mem_wdata equal to the contents of register t (src_data). One cycle after mem_ack they raise done and do not write the register file.
- R6: Opcodes 5 and 6 write the effective address itself into register t. They raise done and rf_we in the cycle after start and never raise a memory strobe.
- R7: A strobe stays high with a stable address while mem_ack is low. It drops in the cycle after mem_ack. mem_rd and mem_wr are never high together.
- R8: A start pulse while an access is pending is ignored: the pending address does not change, and no extra done or register write follows.
- R9: Any other opcode raises done in the cycle after start, with no register write and no memory strobe.
- R10: After reset, mem_rd, mem_wr, rf_we and done are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction valid for one cycle |
| instr | input | 32 | Instruction word |
| pc_next | input | 32 | Address of the following instruction |
| base_sel | output | 5 | Register-file select for the base register |
| src_sel | output | 5 | Register-file select for the store source |
| base_data | input | 32 | Contents of register base_sel |
| src_data | input | 32 | Contents of register src_sel |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rd | output | 1 | Read request, held until completion |
| mem_wr | output | 1 | Write request, held until completion |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory completion |
| rf_we | output | 1 | Register-file write enable |
| rf_wsel | output | 5 | Register-file write select |
| rf_wdata | output | 32 | Register-file write data |
| done | output | 1 | Instruction finished, one cycle |

## Verification
A wrong address decision shows up at mem_addr on the first cycle of the strobe, or at rf_wdata one cycle after start for the address-only opcodes. A lost or stuck pending-access flag shows up within a cycle of mem_ack, as a strobe that stays high, a missing done, or a done with no preceding request. A start that is taken while an access is pending would move mem_addr or add a second done before the next instruction.

// File: rtl/ls_addr_unit.sv
module ls_addr_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] instr,
  input  logic [31:0] pc_next,
  output logic [4:0]  base_sel,
  output logic [4:0]  src_sel,
  input  logic [31:0] base_data,
  input  logic [31:0] src_data,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        mem_rd,
  output logic        mem_wr,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  output logic        rf_we,
  output logic [4:0]  rf_wsel,
  output logic [31:0] rf_wdata,
  output logic        done
);
  localparam logic [4:0] OP_LD  = 5'd1;
  localparam logic [4:0] OP_LDR = 5'd2;
  localparam logic [4:0] OP_ST  = 5'd3;
  localparam logic [4:0] OP_STR = 5'd4;
  localparam logic [4:0] OP_LA  = 5'd5;
  localparam logic [4:0] OP_LAR = 5'd6;

  wire [4:0]  opc     = instr[31:27];
  wire [4:0]  tgt     = instr[26:22];
  wire [31:0] off_s   = {{15{instr[16]}}, instr[16:0]};
  wire [31:0] off_l   = {{10{instr[21]}}, instr[21:0]};
  wire [31:0] disp_ea = (instr[21:17] == 5'd0) ? off_s : base_data + off_s;
  wire [31:0] rel_ea  = pc_next + off_l;
  wire        use_rel = (opc == OP_LDR) || (opc == OP_STR) || (opc == OP_LAR);
  wire [31:0] eff     = use_rel ? rel_ea : disp_ea;
  wire        busy    = mem_rd | mem_wr;
  wire        take    = start & ~busy;

  assign base_sel = instr[21:17];
  assign src_sel  = tgt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      rf_we     <= 1'b0;
      done      <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rf_wsel   <= '0;
      rf_wdata  <= '0;
    end else begin
      rf_we <= 1'b0;
      done  <= 1'b0;
      if (busy) begin
        if (mem_ack) begin
          mem_rd <= 1'b0;
          mem_wr <= 1'b0;
          done   <= 1'b1;
          if (mem_rd) begin
            rf_we    <= 1'b1;
            rf_wdata <= mem_rdata;
          end
        end
      end else if (take) begin
        rf_wsel <= tgt;
        case (opc)
          OP_LD, OP_LDR: begin
            mem_rd   <= 1'b1;
            mem_addr <= eff;
          end
          OP_ST, OP_STR: begin
            mem_wr    <= 1'b1;
            mem_addr  <= eff;
            mem_wdata <= src_data;
          end
          OP_LA, OP_LAR: begin
            rf_we    <= 1'b1;
            rf_wdata <= eff;
            done     <= 1'b1;
          end
          default: done <= 1'b1;
        endcase
      end
    end
  end

  // R7: strobes exclusive
  a_r7_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R7, R8: request held and address frozen until completion
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_ack) |=> (busy && $stable(mem_addr) && !done));
  // R7: strobes drop and done rises after completion
  a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_ack) |=> (!mem_rd && !mem_wr && done));
  // R4: load data written back after completion
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_ack) |=> (rf_we && rf_wdata == $past(mem_rdata)));
  // R5: store finishes without register write
  a_r5_store: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_ack) |=> !rf_we);
  // R6: address-only opcodes finish in one cycle
  a_r6_imm: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (opc == OP_LA || opc == OP_LAR)) |=> (done && rf_we && !busy));
endmodule

// File: tb/sim_ls_addr_unit.sv
module sim_ls_addr_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, start = 0, mem_ack = 0;
  logic [31:0] instr = 0, pc_next = 0, mem_rdata = 0;
  logic [4:0] base_sel, src_sel, rf_wsel;
  logic [31:0] base_data, src_data, mem_addr, mem_wdata, rf_wdata;
  logic mem_rd, mem_wr, rf_we, done;

  logic [31:0] regs [32];
  logic [31:0] mem [64];
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign base_data = regs[base_sel];
  assign src_data  = regs[src_sel];

  ls_addr_unit u0 (.clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc_next(pc_next),
    .base_sel(base_sel), .src_sel(src_sel), .base_data(base_data), .src_data(src_data),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .rf_we(rf_we), .rf_wsel(rf_wsel),
    .rf_wdata(rf_wdata), .done(done));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ea_of(input logic [31:0] iw, input logic [31:0] pcn);
    logic [4:0] op = iw[31:27];
    logic [4:0] b = iw[21:17];
    if (op == 2 || op == 4 || op == 6) return pcn + {{10{iw[21]}}, iw[21:0]};
    if (b == 0) return {{15{iw[16]}}, iw[16:0]};
    return regs[b] + {{15{iw[16]}}, iw[16:0]};
  endfunction

  task automatic run_op(input logic [31:0] iw, input logic [31:0] pcn, input int dly, input bit inject);
    logic [4:0] op = iw[31:27];
    logic [4:0] t = iw[26:22];
    logic [31:0] ea = ea_of(iw, pcn);
    logic [31:0] sdat = regs[t];
    bit seen = 0, fin = 0, ack_prev = 0, injected = 0;
    int cnt = 0, dones = 0;
    @(negedge clk);
    instr = iw; pc_next = pcn; start = 1;
    for (int k = 0; k < 40 && !fin; k++) begin
      @(negedge clk);
      start = 0;
      if (injected) begin
        start = 0;
        instr = iw;
        injected = 0;
      end
      if (ack_prev) begin
        chk(!mem_rd && !mem_wr, "R7 strobe drop", {30'd0, mem_rd, mem_wr}, 0);
        chk(done, "R7 done after ack", {31'd0, done}, 1);
        mem_ack = 0; ack_prev = 0;
      end
      chk(!(mem_rd && mem_wr), "R7 exclusive", {30'd0, mem_rd, mem_wr}, 0);
      if (mem_rd || mem_wr) begin
        chk(mem_addr == ea, (op == 2 || op == 4) ? "R3 rel addr" :
            (iw[21:17] == 0 ? "R1 abs addr" : "R2 disp addr"), mem_addr, ea);
        if (!seen) begin
          seen = 1;
          chk(mem_rd == (op == 1 || op == 2), "R4 read strobe", {31'd0, mem_rd}, {31'd0, (op == 1 || op == 2)});
          chk(mem_wr == (op == 3 || op == 4), "R5 write strobe", {31'd0, mem_wr}, {31'd0, (op == 3 || op == 4)});
          if (mem_wr) chk(mem_wdata == sdat, "R5 store data", mem_wdata, sdat);
          if (inject) begin
            start = 1;
            instr = {5'd5, 5'd7, 22'h000123};
            injected = 1;
          end
        end
        if (cnt == dly) begin
          mem_ack = 1; ack_prev = 1;
          if (mem_rd) mem_rdata = mem[mem_addr[7:2]];
          else mem[mem_addr[7:2]] = mem_wdata;
        end else cnt++;
      end
      if (rf_we) begin
        logic [31:0] exp = (op == 5 || op == 6) ? ea : mem[ea[7:2]];
        chk(op inside {[1:2], [5:6]}, "R5 R9 no reg write", {27'd0, op}, 0);
        chk(rf_wsel == t, "R4 R6 write select", {27'd0, rf_wsel}, {27'd0, t});
        chk(rf_wdata == exp, (op >= 5) ? "R6 address value" : "R4 load data", rf_wdata, exp);
        regs[rf_wsel] = rf_wdata;
      end
      if (done) begin
        dones++;
        fin = 1;
        if (!(op inside {[1:4]})) begin
          chk(k == 0, "R6 R9 one-cycle done", k, 0);
          chk(rf_we == (op == 5 || op == 6), "R9 write only for 5/6", {31'd0, rf_we}, {31'd0, (op == 5 || op == 6)});
        end
      end
    end
    chk(fin, "R4 R5 R6 completion", {31'd0, fin}, 1);
    mem_ack = 0;
    @(negedge clk);
    chk(!done && !rf_we && !mem_rd && !mem_wr, "R8 no extra activity", {28'd0, done, rf_we, mem_rd, mem_wr}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [16:0] shorts [4];
    logic [21:0] longs [4];
    logic [4:0] bases [3];
    int d = 0;
    shorts = '{17'd11, 17'h1FFFC, 17'h0FFFC, 17'h10000};
    longs  = '{22'd11, 22'h3FFFFC, 22'h1FFFFC, 22'h200000};
    bases  = '{5'd0, 5'd3, 5'd9};
    for (int i = 0; i < 32; i++) regs[i] = i * 32'h0101_0104 + 32'h40;
    for (int i = 0; i < 64; i++) mem[i] = 32'hA500_0000 ^ (i * 32'h0003_1F07);
    repeat (3) @(negedge clk);
    chk(!mem_rd && !mem_wr && !rf_we && !done, "R10 reset outputs", {28'd0, mem_rd, mem_wr, rf_we, done}, 0);
    rst_n = 1;
    // directed: load t=5 from register 3 plus 11
    run_op({5'd1, 5'd5, 5'd3, 17'd11}, 32'h0000_1004, 2, 0);
    chk(regs[5] == mem[(regs[3] + 11) >> 2 & 63], "R2 directed load", regs[5], mem[(regs[3] + 11) >> 2 & 63]);
    // sweep opcodes, base choices, offsets and completion delays
    for (int op = 0; op < 8; op++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 4; c++) begin
          logic [31:0] iw;
          if (op == 2 || op == 4 || op == 6)
            iw = {op[4:0], 5'(c * 7 + b + 1), longs[c]};
          else
            iw = {op[4:0], 5'(c * 7 + b + 1), bases[b], shorts[c]};
          run_op(iw, 32'h0000_2000 + 32'(c * 64), d % 6, 0);
          d++;
        end
    run_op({5'd31, 5'd2, 5'd4, 17'd8}, 32'h100, 0, 0);
    // start while pending must be ignored
    run_op({5'd1, 5'd6, 5'd3, 17'd20}, 32'h100, 5, 1);
    run_op({5'd3, 5'd6, 5'd0, 17'd40}, 32'h100, 4, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule